// File: doc/BRIEF.md
# Cyclic Prefix Inserter

This block sits after a transform stage that delivers frames of complex samples in natural order. It stores each incoming frame and emits it with a guard interval in front. The guard interval repeats the closing samples of that same frame, so every output frame holds `cp + N` samples. Here N is the frame size and cp is the prefix length.

The size and the prefix length arrive on a small configuration port. They may differ from frame to frame. The latest written values are latched when a frame's first sample is accepted, and they govern that frame until its last output sample has left. Two frame buffers alternate, so one frame can load while the previous one, prefix included, drains. Both data edges use valid/ready handshakes, and the output carries an end-of-frame flag. A clock enable freezes every register. An active-low synchronous reset is registered once inside the block and takes priority over the enable.

Top module: `cyclic_prefix_inserter`

## Requirements
- R1: Output frame k is samples `N-cp .. N-1` of input frame k followed by samples `0 .. N-1`, each re/im pair unchanged.
- R2: The prefix length is the unsigned value of `cfg_cp` masked to its low log2(N) bits. A written value of N or more therefore acts as `cfg_cp mod N`, and the usable range is 0 to N-1.
- R3: `cfg_size` holds log2(N). Values below 3 act as 3 and values above MAX_LOG2 act as MAX_LOG2.
- R4: The configuration written before a frame's first accepted sample governs that whole frame. A new value applies to the next frame without a stall.
- R5: `out_last` is high only on the final sample of the full frame, never on a prefix sample. With cp = 0 the frame passes through as N samples.
- R6: Once one frame is fully stored and not yet drained, `in_ready` stays high for the next frame. It drops only when both buffers hold unsent frames.
- R7: While `ce` is low, no transfer happens on any port and no state changes.
- R8: While `out_valid` is high and the sample is not taken, `out_valid`, `out_re`, `out_im` and `out_last` hold their values.
- R9: A low `rst_n` sampled at one edge blocks both handshakes after that edge and empties both buffers at the following edge. After reset, `in_ready` = 1 and `out_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, registered internally |
| ce | input | 1 | Clock enable for every register |
| cfg_valid | input | 1 | Write strobe for `cfg_size` and `cfg_cp` |
| cfg_size | input | LW | log2 of the frame size |
| cfg_cp | input | MAX_LOG2 | Prefix length |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take an input sample |
| in_re | input | DATA_W | Input real part |
| in_im | input | DATA_W | Input imaginary part |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes the output sample |
| out_re | output | DATA_W | Output real part |
| out_im | output | DATA_W | Output imaginary part |
| out_last | output | 1 | Final sample of an output frame |

## Verification
The bench sweeps every prefix length for every frame size. This exposes a wrap error in the read address: a wrong address would repeat the head of the frame instead of its tail, or shift the body by one. Out-of-range size and prefix values are written on purpose, so a design that fails to mask or clamp them produces frames of the wrong length. Random back-pressure and random enable gaps catch a design that advances while stalled or reorders samples. A single-cycle reset pulse and a two-frame fill with the output blocked catch early flag removal and buffers that survive reset.

// File: rtl/cpi_pkg.sv
package cpi_pkg;
  localparam int unsigned MIN_LOG2 = 3;

  function automatic int unsigned clamp_size(int unsigned req, int unsigned hi);
    if (req < MIN_LOG2) return MIN_LOG2;
    if (req > hi) return hi;
    return req;
  endfunction
endpackage

// File: rtl/cpi_bank_mem.sv
module cpi_bank_mem #(
  parameter int SW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          we,
  input  logic [AW:0]   waddr,
  input  logic [SW-1:0] wdata,
  input  logic [AW:0]   raddr,
  output logic [SW-1:0] rdata
);
  localparam int ENTRIES = 2 ** (AW + 1);

  logic [SW-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (ce && we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/cpi_wr_ctrl.sv
module cpi_wr_ctrl
  import cpi_pkg::*;
#(
  parameter int MAX_LOG2 = 6,
  parameter int LW       = 3
) (
  input  logic                         clk,
  input  logic                         rst_q,
  input  logic                         ce,
  input  logic                         cfg_valid,
  input  logic [LW-1:0]                cfg_size,
  input  logic [MAX_LOG2-1:0]          cfg_cp,
  input  logic                         in_valid,
  input  logic [1:0]                   full_q,
  output logic                         in_ready,
  output logic                         wr_en,
  output logic                         wr_bank,
  output logic [MAX_LOG2-1:0]          wr_addr,
  output logic                         set_full,
  output logic [1:0][LW-1:0]           bank_lg,
  output logic [1:0][MAX_LOG2-1:0]     bank_cp
);
  localparam int AW = MAX_LOG2;

  logic [LW-1:0]         pend_lg_q, pend_lg_d;
  logic [AW-1:0]         pend_cp_q, pend_cp_d;
  logic                  bank_q, bank_d;
  logic [AW-1:0]         cnt_q, cnt_d;
  logic [1:0][LW-1:0]    lg_q, lg_d;
  logic [1:0][AW-1:0]    cp_q, cp_d;
  logic [LW-1:0]         cur_lg;
  logic [AW-1:0]         last_idx;

  always_comb begin
    in_ready  = rst_q & ~full_q[bank_q];
    wr_en     = in_valid & in_ready & ce;
    pend_lg_d = pend_lg_q;
    pend_cp_d = pend_cp_q;
    if (cfg_valid) begin
      pend_lg_d = LW'(clamp_size(32'(cfg_size), MAX_LOG2));
      pend_cp_d = cfg_cp;
    end
    cur_lg   = (cnt_q == '0) ? pend_lg_q : lg_q[bank_q];
    last_idx = AW'((1 << cur_lg) - 1);
    lg_d     = lg_q;
    cp_d     = cp_q;
    bank_d   = bank_q;
    cnt_d    = cnt_q;
    set_full = 1'b0;
    if (wr_en) begin
      if (cnt_q == '0) begin
        lg_d[bank_q] = pend_lg_q;
        cp_d[bank_q] = pend_cp_q & last_idx;
      end
      if (cnt_q == last_idx) begin
        cnt_d    = '0;
        bank_d   = ~bank_q;
        set_full = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_q) begin
      pend_lg_q <= LW'(MIN_LOG2);
      pend_cp_q <= '0;
      bank_q    <= 1'b0;
      cnt_q     <= '0;
      lg_q      <= {2{LW'(MIN_LOG2)}};
      cp_q      <= '0;
    end else if (ce) begin
      pend_lg_q <= pend_lg_d;
      pend_cp_q <= pend_cp_d;
      bank_q    <= bank_d;
      cnt_q     <= cnt_d;
      lg_q      <= lg_d;
      cp_q      <= cp_d;
    end
  end

  assign wr_bank = bank_q;
  assign wr_addr = cnt_q;
  assign bank_lg = lg_q;
  assign bank_cp = cp_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank_chk
    assert_cfg_frozen_R4 : assert property (@(posedge clk) disable iff (!rst_q)
      (full_q[b] && $past(full_q[b])) |-> ($stable(lg_q[b]) && $stable(cp_q[b])));
    assert_cp_below_size_R2 : assert property (@(posedge clk) disable iff (!rst_q)
      32'(cp_q[b]) < (32'd1 << lg_q[b]));
  end
endmodule

// File: rtl/cpi_rd_ctrl.sv
module cpi_rd_ctrl #(
  parameter int MAX_LOG2 = 6,
  parameter int LW       = 3
) (
  input  logic                     clk,
  input  logic                     rst_q,
  input  logic                     ce,
  input  logic [1:0]               full_q,
  input  logic [1:0][LW-1:0]       bank_lg,
  input  logic [1:0][MAX_LOG2-1:0] bank_cp,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic                     out_last,
  output logic                     rd_bank,
  output logic [MAX_LOG2-1:0]      rd_addr,
  output logic                     clr_full
);
  localparam int PW = MAX_LOG2 + 1;

  logic [PW-1:0] pos_q, pos_d;
  logic [PW-1:0] size_n, cp_ext, final_pos, offs;
  logic          bank_q, bank_d;
  logic          take;

  always_comb begin
    size_n    = PW'(1 << bank_lg[bank_q]);
    cp_ext    = {1'b0, bank_cp[bank_q]};
    final_pos = cp_ext + size_n - 1'b1;
    offs      = (pos_q - cp_ext) & (size_n - 1'b1);
    rd_addr   = offs[MAX_LOG2-1:0];
    out_valid = rst_q & full_q[bank_q];
    out_last  = out_valid & (pos_q == final_pos);
    take      = out_valid & out_ready & ce;
    pos_d     = pos_q;
    bank_d    = bank_q;
    clr_full  = 1'b0;
    if (take) begin
      if (pos_q == final_pos) begin
        pos_d    = '0;
        bank_d   = ~bank_q;
        clr_full = 1'b1;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_q) begin
      pos_q  <= '0;
      bank_q <= 1'b0;
    end else if (ce) begin
      pos_q  <= pos_d;
      bank_q <= bank_d;
    end
  end

  assign rd_bank = bank_q;

  assert_pos_in_frame_R1 : assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> (pos_q <= final_pos));
endmodule

// File: rtl/cyclic_prefix_inserter.sv
module cyclic_prefix_inserter #(
  parameter int DATA_W   = 16,
  parameter int MAX_LOG2 = 6,
  parameter int LW       = $clog2(MAX_LOG2 + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce,
  input  logic                cfg_valid,
  input  logic [LW-1:0]       cfg_size,
  input  logic [MAX_LOG2-1:0] cfg_cp,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_re,
  input  logic [DATA_W-1:0]   in_im,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_re,
  output logic [DATA_W-1:0]   out_im,
  output logic                out_last
);
  localparam int SW = 2 * DATA_W;
  localparam int AW = MAX_LOG2;

  logic                 rst_q;
  logic [1:0]           full_q, full_d;
  logic                 wr_en, wr_bank, set_full;
  logic [AW-1:0]        wr_addr, rd_addr;
  logic                 rd_bank, clr_full;
  logic [1:0][LW-1:0]   bank_lg;
  logic [1:0][AW-1:0]   bank_cp;
  logic [SW-1:0]        rdata;

  always_ff @(posedge clk) rst_q <= rst_n;

  always_comb begin
    full_d = full_q;
    if (set_full) full_d[wr_bank] = 1'b1;
    if (clr_full) full_d[rd_bank] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_q)  full_q <= '0;
    else if (ce) full_q <= full_d;
  end

  cpi_wr_ctrl #(.MAX_LOG2(MAX_LOG2), .LW(LW)) u_wr (
    .clk(clk), .rst_q(rst_q), .ce(ce),
    .cfg_valid(cfg_valid), .cfg_size(cfg_size), .cfg_cp(cfg_cp),
    .in_valid(in_valid), .full_q(full_q), .in_ready(in_ready),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .set_full(set_full),
    .bank_lg(bank_lg), .bank_cp(bank_cp)
  );

  cpi_rd_ctrl #(.MAX_LOG2(MAX_LOG2), .LW(LW)) u_rd (
    .clk(clk), .rst_q(rst_q), .ce(ce), .full_q(full_q),
    .bank_lg(bank_lg), .bank_cp(bank_cp), .out_ready(out_ready),
    .out_valid(out_valid), .out_last(out_last), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .clr_full(clr_full)
  );

  cpi_bank_mem #(.SW(SW), .AW(AW)) u_mem (
    .clk(clk), .ce(ce), .we(wr_en),
    .waddr({wr_bank, wr_addr}), .wdata({in_re, in_im}),
    .raddr({rd_bank, rd_addr}), .rdata(rdata)
  );

  assign out_re = rdata[SW-1:DATA_W];
  assign out_im = rdata[DATA_W-1:0];

  assert_hold_R8 : assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !(out_ready && ce)) |=>
      (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_last)));
  assert_no_overfill_R6 : assert property (@(posedge clk) disable iff (!rst_q)
    in_ready |-> !(full_q[0] && full_q[1]));
  assert_frozen_R7 : assert property (@(posedge clk) disable iff (!rst_q)
    !ce |=> $stable(full_q));
endmodule

// File: tb/sim_cyclic_prefix_inserter.sv
module sim_cyclic_prefix_inserter;
  localparam int DATA_W   = 10;
  localparam int MAX_LOG2 = 5;
  localparam int LW       = $clog2(MAX_LOG2 + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b1;
  logic cfg_valid = 1'b0;
  logic [LW-1:0] cfg_size = '0;
  logic [MAX_LOG2-1:0] cfg_cp = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DATA_W-1:0] in_re = '0, in_im = '0;
  logic out_valid, out_last;
  logic out_ready = 1'b0;
  logic [DATA_W-1:0] out_re, out_im;

  int total = 0, bad = 0, cyc = 0;
  int lg_q[$], cp_q[$];
  string tag_q[$];
  bit bp_on = 0, ce_rand = 0, ce_hold = 0;

  always #4 clk = ~clk;

  cyclic_prefix_inserter #(.DATA_W(DATA_W), .MAX_LOG2(MAX_LOG2)) u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .cfg_valid(cfg_valid), .cfg_size(cfg_size),
    .cfg_cp(cfg_cp), .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re),
    .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re),
    .out_im(out_im), .out_last(out_last)
  );

  always @(negedge clk) ce <= ce_hold ? 1'b0 : (ce_rand ? ($urandom % 5 != 0) : 1'b1);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int eff_lg(int raw);
    return raw < 3 ? 3 : (raw > MAX_LOG2 ? MAX_LOG2 : raw);
  endfunction
  function automatic int eff_cp(int f);
    return cp_q[f] & ((1 << eff_lg(lg_q[f])) - 1);
  endfunction
  function automatic logic [DATA_W-1:0] pat_re(int f, int i);
    return DATA_W'(f * 37 + i * 5);
  endfunction
  function automatic logic [DATA_W-1:0] pat_im(int f, int i);
    return DATA_W'(f * 11 + i * 3 + 1);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic add(int lg, int cp, string tag);
    lg_q.push_back(lg); cp_q.push_back(cp); tag_q.push_back(tag);
  endtask

  task automatic tx_range(int lo, int hi);
    for (int f = lo; f < hi; f++) begin
      @(negedge clk);
      cfg_valid = 1'b1; cfg_size = LW'(lg_q[f]); cfg_cp = MAX_LOG2'(cp_q[f]);
      #1;
      while (!ce) begin @(negedge clk); #1; end
      @(negedge clk);
      cfg_valid = 1'b0;
      for (int i = 0; i < (1 << eff_lg(lg_q[f])); i++) begin
        in_valid = 1'b1; in_re = pat_re(f, i); in_im = pat_im(f, i);
        #1;
        while (!(in_ready && ce)) begin @(negedge clk); #1; end
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
  endtask

  task automatic rx_range(int lo, int hi);
    for (int f = lo; f < hi; f++) begin
      int n = 1 << eff_lg(lg_q[f]);
      int cp = eff_cp(f);
      int derr = 0, lerr = 0, dact = 0, dexp = 0;
      for (int j = 0; j < cp + n; j++) begin
        int idx = (j < cp) ? n - cp + j : j - cp;
        @(negedge clk);
        out_ready = bp_on ? ($urandom % 4 != 0) : 1'b1;
        #1;
        while (!(out_valid && out_ready && ce)) begin
          @(negedge clk);
          out_ready = bp_on ? ($urandom % 4 != 0) : 1'b1;
          #1;
        end
        if (out_re != pat_re(f, idx) || out_im != pat_im(f, idx)) begin
          if (derr == 0) begin dact = int'(out_re); dexp = int'(pat_re(f, idx)); end
          derr++;
        end
        if (out_last != (j == cp + n - 1)) lerr++;
      end
      chk(derr == 0, tag_q[f], dact, dexp);
      chk(lerr == 0, "R5 last flag", lerr, 0);
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_batch(int lo, int hi);
    fork
      tx_range(lo, hi);
      rx_range(lo, hi);
    join
  endtask

  initial begin
    int base;
    logic [DATA_W-1:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);

    // R1 / R4: every prefix length for every size, config changes per frame
    base = lg_q.size();
    for (int lg = 3; lg <= MAX_LOG2; lg++)
      for (int cp = 0; cp < (1 << lg); cp++) add(lg, cp, "R1 sweep");
    run_batch(base, lg_q.size());

    // R2 masking and R3 clamping
    base = lg_q.size();
    add(3, 13, "R2 cp masked");
    add(4, 31, "R2 cp masked");
    add(2, 5, "R3 size low clamp");
    add(7, 20, "R3 size high clamp");
    add(0, 0, "R5 cp zero");
    run_batch(base, lg_q.size());

    // R6 ping-pong fill with output blocked, then R7 enable hold
    base = lg_q.size();
    add(3, 2, "R6 first frame");
    add(4, 9, "R6 second frame");
    tx_range(base, base + 1);
    #1;
    chk(in_ready == 1'b1, "R6 ready after one frame", in_ready, 1);
    tx_range(base + 1, base + 2);
    #1;
    chk(in_ready == 1'b0, "R6 ready with both full", in_ready, 0);
    chk(out_valid == 1'b1, "R6 output pending", out_valid, 1);
    ce_hold = 1'b1;
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    held = out_re;
    repeat (3) @(negedge clk);
    #1;
    chk(out_re == held, "R7 frozen data", int'(out_re), int'(held));
    chk(out_valid == 1'b1, "R7 frozen valid", out_valid, 1);
    ce_hold = 1'b0;
    out_ready = 1'b0;
    rx_range(base, base + 2);

    // R4 / R7 / R8: random back-pressure and enable gaps, mixed configs
    bp_on = 1; ce_rand = 1;
    base = lg_q.size();
    for (int k = 0; k < 60; k++)
      add(3 + int'($urandom % 3), int'($urandom % 32), "R8 backpressure");
    run_batch(base, lg_q.size());
    bp_on = 0; ce_rand = 0;

    // R9 single-cycle reset pulse with a stored frame
    base = lg_q.size();
    add(3, 4, "R9 dropped frame");
    tx_range(base, base + 1);
    #1;
    chk(out_valid == 1'b1, "R9 stored before pulse", out_valid, 1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R9 handshake blocked", in_ready, 0);
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R9 buffer emptied", out_valid, 0);
    chk(in_ready == 1'b1, "R9 ready after pulse", in_ready, 1);
    base = lg_q.size();
    add(4, 3, "R9 frame after pulse");
    run_batch(base, lg_q.size());

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule